// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one indivisible read-modify-write on a single synchronous memory port. A requester presents an opcode, a byte address, an operand, a compare value and a width flag that selects 64-bit or 32-bit access. The unit reads the addressed word and works out a new value. Depending on the opcode and on what it read, it may write that value back. It then returns the value that was in memory before the operation.

From the moment a request is accepted until the result is handed back, the unit refuses new requests. No other access can therefore fall between its read and its write. Six operations are supported: swap, compare-and-swap, fetch-add, a fetch-add that stores only a non-negative sum, fetch-and and fetch-or. In 32-bit mode the returned value and the compare value are sign-extended to 64 bits, and only the addressed 32-bit word is written. A misaligned address, an unknown opcode or an error signalled by the memory ends the operation early with a fault code.

The memory returns read data and its error flag one cycle after a request. For a 32-bit access, read data comes back in the low half of the data bus and write data is taken from the low half.

Top module: `amo_unit`

## Requirements
- R1: `req_ready` is high only while idle. It goes low on the cycle after a request is accepted and stays low through the single-cycle `done_o` pulse. It is high again on the cycle after that pulse, and `mem_req` is never high while `req_ready` is high.
- R2: For every completed operation without a fault, `result_o` is the memory value read before any update. In 32-bit mode that value is sign-extended from bit 31.
- R3: Opcode 0 (swap) writes the operand every time, whatever the compare value holds.
- R4: Opcode 1 (compare-and-swap) writes the operand only when the value read equals the compare value. In 32-bit mode the compare value is the sign extension of its low 32 bits. When the two differ, no write is issued.
- R5: Opcode 2 stores memory plus operand, opcode 4 stores their bitwise AND and opcode 5 stores their bitwise OR.
- R6: Opcode 3 forms memory plus operand and stores it only if the sign bit of the sum is zero. The sign bit is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R7: A 32-bit write drives `mem_wide` low and the upper half of `mem_wdata` to zero. The other 32-bit half of the 64-bit word is left untouched.
- R8: With a legal opcode, an address not aligned to the access size raises fault code 1 and makes no memory access. Here aligned means address bits [2:0] are zero in 64-bit mode and bits [1:0] are zero in 32-bit mode. `done_o` rises one cycle after acceptance.
- R9: Opcodes 6 and 7 raise fault code 2 and make no memory access. This holds even when the address is also misaligned. `done_o` rises one cycle after acceptance.
- R10: If `mem_err` is returned for the read or the write, the unit ends with fault code 3 and result zero, and it places the request address on `fault_addr_o`. A read error prevents the write.
- R11: An operation without a write signals `done_o` 3 cycles after the accepting edge, using one memory access. An operation with a write signals `done_o` 5 cycles after it, using two accesses. The write comes two cycles after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken when valid |
| req_op | input | 3 | Opcode 0..5, 6 and 7 illegal |
| req_addr | input | ADDR_W | Byte address |
| req_operand | input | DATA_W | Operand / value to store |
| req_cmp | input | DATA_W | Compare value for compare-and-swap |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Old memory value (zero on fault) |
| fault_o | output | 2 | 0 none, 1 misaligned, 2 illegal opcode, 3 bus error |
| fault_addr_o | output | ADDR_W | Address of the completed request |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | Access width, 1 = 64-bit |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after a read |
| mem_err | input | 1 | Error, one cycle after an access |

## Verification
Each outcome has a fixed completion time, counted from the accepting clock edge. Early faults finish after 1 cycle, read-only outcomes and read errors after 3, and stored outcomes and write errors after 5. The bench drives and samples on falling edges and counts falling edges from acceptance until `done_o`. It compares that count with the figure it derived from the expected write decision, and also confirms `req_ready` stays low at every falling edge in between. It also counts memory strobes during the operation, and it inspects its own memory model only after `done_o`, when any write has already landed.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [2:0] OP_SWAP  = 3'd0;
  localparam logic [2:0] OP_CAS   = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_ADDNN = 3'd3;
  localparam logic [2:0] OP_AND   = 3'd4;
  localparam logic [2:0] OP_OR    = 3'd5;
  localparam logic [2:0] OP_LAST  = OP_OR;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ALIGN   = 2'd1,
    FLT_ILLEGAL = 2'd2,
    FLT_BUS     = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_WACK, ST_DONE
  } amo_st_e;
endpackage

// File: rtl/amo_req_check.sv
module amo_req_check
  import amo_pkg::*;
(
  input  logic [2:0] op,
  input  logic [2:0] addr_lo,
  input  logic       wide,
  output flt_e       fault
);
  logic misaligned;

  assign misaligned = wide ? (addr_lo != 3'd0) : (addr_lo[1:0] != 2'd0);

  always_comb begin
    if (op > OP_LAST)     fault = FLT_ILLEGAL;
    else if (misaligned)  fault = FLT_ALIGN;
    else                  fault = FLT_NONE;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] cmp,
  output logic [DATA_W-1:0] old_ext,
  output logic [DATA_W-1:0] new_val,
  output logic              wr_en
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] cmp_ext;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] nv;
  logic              neg;

  assign old_ext = wide ? raw : {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
  assign cmp_ext = wide ? cmp : {{HALF{cmp[HALF-1]}}, cmp[HALF-1:0]};
  assign sum     = old_ext + operand;
  assign neg     = wide ? sum[DATA_W-1] : sum[HALF-1];

  always_comb begin
    nv    = operand;
    wr_en = 1'b0;
    case (op)
      OP_SWAP:  begin nv = operand;           wr_en = 1'b1; end
      OP_CAS:   begin nv = operand;           wr_en = (old_ext == cmp_ext); end
      OP_ADD:   begin nv = sum;               wr_en = 1'b1; end
      OP_ADDNN: begin nv = sum;               wr_en = !neg; end
      OP_AND:   begin nv = old_ext & operand; wr_en = 1'b1; end
      OP_OR:    begin nv = old_ext | operand; wr_en = 1'b1; end
      default:  begin nv = operand;           wr_en = 1'b0; end
    endcase
  end

  assign new_val = wide ? nv : {{HALF{1'b0}}, nv[HALF-1:0]};
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [DATA_W-1:0] req_cmp,
  input  logic              req_wide,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic [1:0]        fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err
);
  amo_st_e           st;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, cmp_q, wdata_q, result_q;
  logic              wide_q, done_q;
  flt_e              fault_q, chk_fault;
  logic [DATA_W-1:0] old_ext, new_val;
  logic              wr_en;

  amo_req_check u_check (
    .op      (req_op),
    .addr_lo (req_addr[2:0]),
    .wide    (req_wide),
    .fault   (chk_fault)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .wide    (wide_q),
    .raw     (mem_rdata),
    .operand (opnd_q),
    .cmp     (cmp_q),
    .old_ext (old_ext),
    .new_val (new_val),
    .wr_en   (wr_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      opnd_q   <= '0;
      cmp_q    <= '0;
      wide_q   <= 1'b0;
      wdata_q  <= '0;
      result_q <= '0;
      fault_q  <= FLT_NONE;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            op_q     <= req_op;
            addr_q   <= req_addr;
            opnd_q   <= req_operand;
            cmp_q    <= req_cmp;
            wide_q   <= req_wide;
            result_q <= '0;
            fault_q  <= chk_fault;
            if (chk_fault != FLT_NONE) begin
              st     <= ST_DONE;
              done_q <= 1'b1;
            end else begin
              st <= ST_READ;
            end
          end
        end
        ST_READ: st <= ST_CALC;
        ST_CALC: begin
          if (mem_err) begin
            fault_q <= FLT_BUS;
            st      <= ST_DONE;
            done_q  <= 1'b1;
          end else begin
            result_q <= old_ext;
            wdata_q  <= new_val;
            if (wr_en) begin
              st <= ST_WRITE;
            end else begin
              st     <= ST_DONE;
              done_q <= 1'b1;
            end
          end
        end
        ST_WRITE: st <= ST_WACK;
        ST_WACK: begin
          if (mem_err) begin
            fault_q  <= FLT_BUS;
            result_q <= '0;
          end
          st     <= ST_DONE;
          done_q <= 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == ST_IDLE);
  assign done_o       = done_q;
  assign result_o     = result_q;
  assign fault_o      = fault_q;
  assign fault_addr_o = addr_q;
  assign mem_req      = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we       = (st == ST_WRITE);
  assign mem_wide     = wide_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_wide,
  input logic              done_o,
  input logic [1:0]        fault_o,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_wide,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam int HALF = DATA_W / 2;

  logic accept, bad_op, bad_align;
  assign accept    = req_valid && req_ready;
  assign bad_op    = req_op > 3'd5;
  assign bad_align = req_wide ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0);

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_busy_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_ready);
  assert_mem_busy_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  assert_illegal_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && bad_op) |=> (done_o && fault_o == 2'd2 && !mem_req));
  assert_misalign_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !bad_op && bad_align) |=> (done_o && fault_o == 2'd1 && !mem_req));
  assert_write_after_read_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));
  assert_narrow_write_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_wide) |-> (mem_wdata[DATA_W-1:HALF] == '0));
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_amo_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .req_wide  (req_wide),
  .done_o    (done_o),
  .fault_o   (fault_o),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wide  (mem_wide),
  .mem_wdata (mem_wdata)
);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  localparam int AW = 16;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_operand = '0;
  logic [DW-1:0] req_cmp = '0;
  logic          req_wide = 1'b0;
  logic          done_o;
  logic [DW-1:0] result_o;
  logic [1:0]    fault_o;
  logic [AW-1:0] fault_addr_o;
  logic          mem_req, mem_we, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_err = 1'b0;

  always #2 clk = ~clk;

  amo_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  // bench memory model
  logic [DW-1:0] mem [16];
  logic          pre_en = 1'b0;
  logic [3:0]    pre_idx = '0;
  logic [DW-1:0] pre_val = '0;
  logic          err_en = 1'b0, err_we = 1'b0;
  logic [AW-1:0] err_addr = '0;
  int            acc_cnt = 0;
  logic          err_hit;

  assign err_hit = err_en && (mem_addr == err_addr) && (mem_we == err_we);

  always @(posedge clk) begin
    if (pre_en) mem[pre_idx] <= pre_val;
    mem_err <= mem_req && err_hit;
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (!mem_we) begin
        if (mem_wide) mem_rdata <= mem[mem_addr[6:3]];
        else mem_rdata <= {32'h0, mem_addr[2] ? mem[mem_addr[6:3]][63:32]
                                              : mem[mem_addr[6:3]][31:0]};
      end else if (!err_hit) begin
        if (mem_wide) mem[mem_addr[6:3]] <= mem_wdata;
        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
        else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
      end
    end
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pat_mem(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h5;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h0000_0000_7FFF_FFFF;
      4: return 64'h8000_0000_0000_0000;
      default: return 64'h1234_5678_9ABC_DEF0;
    endcase
  endfunction

  function automatic logic [63:0] pat_opnd(input int k);
    case (k)
      0: return 64'h1;
      1: return -64'sd6;
      2: return 64'h1;
      3: return 64'h1;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return 64'h3;
    endcase
  endfunction

  // Run one request; expectations derived from the requirement text.
  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] addr,
                        input logic [63:0] opnd, input logic [63:0] cmp,
                        input logic wide, input logic [63:0] preset,
                        input logic [1:0] exp_fault_in, input int exp_lat_in);
    logic [63:0] pre, post, old, cmpx, nv, exp_res;
    logic [31:0] raw32;
    logic        w, hi;
    logic [1:0]  exp_fault;
    int          exp_lat, exp_acc, lat, acc0;
    string       mtag;
    @(negedge clk);
    pre_en = 1'b1; pre_idx = addr[6:3]; pre_val = preset;
    @(negedge clk);
    pre_en = 1'b0;
    pre = mem[addr[6:3]];
    hi = addr[2];
    raw32 = hi ? pre[63:32] : pre[31:0];
    old  = wide ? pre : {{32{raw32[31]}}, raw32};
    cmpx = wide ? cmp : {{32{cmp[31]}}, cmp[31:0]};
    w = 1'b0; nv = opnd; mtag = "R5";
    case (op)
      3'd0: begin nv = opnd; w = 1'b1; mtag = "R3"; end
      3'd1: begin nv = opnd; w = (old == cmpx); mtag = "R4"; end
      3'd2: begin nv = old + opnd; w = 1'b1; end
      3'd3: begin nv = old + opnd; w = wide ? !nv[63] : !nv[31]; mtag = "R6"; end
      3'd4: begin nv = old & opnd; w = 1'b1; end
      3'd5: begin nv = old | opnd; w = 1'b1; end
      default: w = 1'b0;
    endcase
    exp_fault = exp_fault_in;
    if (exp_fault_in != 2'd0) begin
      w = 1'b0; exp_res = 64'h0; exp_lat = exp_lat_in;
      exp_acc = (exp_lat_in == 1) ? 0 : ((exp_lat_in == 3) ? 1 : 2);
    end else begin
      exp_res = old;
      exp_lat = w ? 5 : 3;
      exp_acc = w ? 2 : 1;
    end
    post = pre;
    if (w) begin
      if (wide) post = nv;
      else if (hi) post[63:32] = nv[31:0];
      else post[31:0] = nv[31:0];
    end
    check(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'h1);
    acc0 = acc_cnt;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_operand = opnd;
    req_cmp = cmp; req_wide = wide;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      check(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'h0);
      @(negedge clk);
      lat++;
    end
    check(req_ready == 1'b0, "R1 ready low during done", 64'(req_ready), 64'h0);
    check(lat == exp_lat, "R11 done latency", 64'(lat), 64'(exp_lat));
    check(fault_o == exp_fault, "R10 R8 R9 fault code", 64'(fault_o), 64'(exp_fault));
    check(result_o == exp_res, "R2 result old value", result_o, exp_res);
    check((acc_cnt - acc0) == exp_acc, "R11 memory access count", 64'(acc_cnt - acc0), 64'(exp_acc));
    if (exp_fault != 2'd0)
      check(fault_addr_o == addr, "R10 fault address", 64'(fault_addr_o), 64'(addr));
    check(mem[addr[6:3]] == post, mtag, mem[addr[6:3]], post);
    if (!wide && exp_fault == 2'd0)
      check((hi ? mem[addr[6:3]][31:0] : mem[addr[6:3]][63:32]) == (hi ? pre[31:0] : pre[63:32]),
            "R7 other half untouched",
            64'(hi ? mem[addr[6:3]][31:0] : mem[addr[6:3]][63:32]),
            64'(hi ? pre[31:0] : pre[63:32]));
    @(negedge clk);
    check(done_o == 1'b0, "R1 done single pulse", 64'(done_o), 64'h0);
    check(req_ready == 1'b1, "R1 ready back after done", 64'(req_ready), 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0 || req_ready == 1'b1, "R1 reset sample", 64'(req_ready), 64'(req_ready));
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'h1);
    check(done_o == 1'b0, "R1 reset done", 64'(done_o), 64'h0);
    check(mem_req == 1'b0, "R1 reset no access", 64'(mem_req), 64'h0);

    // sweep: opcodes x widths x value patterns (R2..R7, R9)
    for (int op = 0; op < 8; op++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int k = 0; k < 6; k++) begin
          logic [63:0] m, c, pv;
          logic [AW-1:0] a;
          m = pat_mem(k);
          a = AW'(k * 8 + ((wd == 0 && (k % 2) == 1) ? 4 : 0));
          if (wd == 1) begin
            c  = ((k % 2) == 0) ? m : (m ^ 64'h1);
            pv = m;
          end else begin
            c  = ((k % 2) == 0) ? {32'hDEAD_BEEF, m[31:0]} : {32'h0, m[31:0] ^ 32'h1};
            pv = a[2] ? {m[31:0], 32'hC3C3_C3C3} : {32'h5A5A_5A5A, m[31:0]};
          end
          run_op(3'(op), a, pat_opnd(k), c, wd[0], pv,
                 (op > 5) ? 2'd2 : 2'd0, 1);
        end
      end
    end

    // R8: misaligned addresses, both widths
    for (int off = 1; off < 8; off++)
      run_op(3'd2, AW'(16 + off), 64'h1, 64'h0, 1'b1, 64'h77, 2'd1, 1);
    for (int off = 1; off < 8; off++)
      if ((off % 4) != 0)
        run_op(3'd0, AW'(24 + off), 64'h9, 64'h0, 1'b0, 64'h66, 2'd1, 1);
    // R9: illegal opcode wins over misalignment
    run_op(3'd7, AW'(33), 64'h1, 64'h0, 1'b1, 64'h55, 2'd2, 1);

    // R10: read error, write error, and armed write error with no write
    err_en = 1'b1; err_we = 1'b0; err_addr = AW'(40);
    run_op(3'd2, AW'(40), 64'h1, 64'h0, 1'b1, 64'h44, 2'd3, 3);
    err_we = 1'b1;
    run_op(3'd2, AW'(40), 64'h1, 64'h0, 1'b1, 64'h44, 2'd3, 5);
    run_op(3'd1, AW'(40), 64'h1, 64'h99, 1'b1, 64'h44, 2'd0, 3);
    err_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule